// File: doc/BRIEF.md
# Acknowledged serial link transmitter

This block drives the outgoing wire of a full-duplex byte link in which every data byte must be acknowledged by the far end. Two sources feed it. The host loads data bytes, and the local receiver asks for acknowledge packets after it has accepted a byte from the far end. The block turns each request into a packet on one wire. The line rests low between packets. A data packet takes eleven bit times and an acknowledge packet takes two.

Flow control comes from the opposite wire, not from a handshake at the host side. Once a data byte is loaded, the host must wait for `ready_o` to rise again. That happens only after the byte has left the wire and the receiver has reported an incoming acknowledge. The bit time is a whole number of clock cycles, picked by a speed select input. The divider is chosen per packet when the packet starts.

Top module: `ack_link_tx`

## Requirements
- R1: While `rst_ni` is low, `line_o` is low and `ready_o` is high.
- R2: With no packet in flight, `line_o` is low. After each packet, the line stays low for at least one clock cycle before the next packet starts.
- R3: A data packet drives these bits on `line_o`, in time order: 1, 1, then data bits 0 through 7 (least significant bit first), then 0. That is 11 bit times.
- R4: An acknowledge packet drives 1 and then 0 on `line_o`, for 2 bit times.
- R5: Each bit lasts `DIV_SLOW` clock cycles when `fast_i` was 0 in the cycle the packet started, and `DIV_FAST` cycles when it was 1. Changing `fast_i` during a packet has no effect on that packet.
- R6: A load accepted while `ready_o` is high makes `ready_o` low in the next cycle. If the line is idle, the start bit appears two cycles after the load cycle.
- R7: `ready_o` rises one cycle after an `ack_rcvd_i` pulse, but only if that pulse comes after the loaded byte's stop bit has finished. An earlier pulse is ignored, and `ready_o` stays low.
- R8: A load while `ready_o` is low is ignored: the byte sent on the wire is the one accepted earlier.
- R9: An acknowledge request that arrives during a data packet is held. It is sent after that packet's stop bit and the idle cycle that follows.
- R10: When an acknowledge request and a data byte are both waiting at an idle line, the acknowledge packet goes first and the data packet follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_i | input | 1 | Speed select: 1 picks the short bit time |
| load_i | input | 1 | Host strobe that loads a data byte |
| load_data_i | input | 8 | Byte to send |
| ack_req_i | input | 1 | Request from the local receiver to send an acknowledge |
| ack_rcvd_i | input | 1 | Pulse from the local receiver: an acknowledge arrived |
| line_o | output | 1 | Serial output wire |
| ready_o | output | 1 | High when the host may load a byte |

## Verification
Each output has a fixed latency:
- `ready_o` falls one cycle after an accepted load and rises one cycle after a qualifying `ack_rcvd_i`.
- A start bit appears two cycles after its request when the line is idle.
- Each bit then holds for exactly the divider count.
- Packets are separated by one low cycle.

The bench has a reference model that keeps the expected line levels in a queue. It pushes the full bit sequence when a packet starts and pops one value per clock. The model is compared with both outputs at every falling edge, so any early or late transition fails in the exact cycle it occurs. Directed stimulus covers early acknowledges, loads while busy, speed changes during a packet, and simultaneous requests.

// File: rtl/ack_link_pkg.sv
package ack_link_pkg;
  typedef enum logic {PKT_ACK = 1'b0, PKT_DATA = 1'b1} pkt_kind_e;

  localparam int FRAME_W  = 11;
  localparam int DATA_LEN = 11;
  localparam int ACK_LEN  = 2;
  localparam int LEFT_W   = $clog2(FRAME_W);

  // bit 0 goes out first
  function automatic logic [FRAME_W-1:0] frame_bits(pkt_kind_e kind, logic [7:0] data);
    if (kind == PKT_DATA) frame_bits = {1'b0, data, 1'b1, 1'b1};
    else                  frame_bits = {{(FRAME_W-2){1'b0}}, 1'b0, 1'b1};
  endfunction

  function automatic logic [LEFT_W-1:0] frame_last(pkt_kind_e kind);
    frame_last = (kind == PKT_DATA) ? LEFT_W'(DATA_LEN - 1) : LEFT_W'(ACK_LEN - 1);
  endfunction
endpackage

// File: rtl/ack_link_bit_timer.sv
module ack_link_bit_timer #(
  parameter int DIV_SLOW = 8,
  parameter int DIV_FAST = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fast_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [CW-1:0] cnt_q, period_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= '0;
    end else if (start_i) begin
      period_q <= fast_i ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
      cnt_q    <= fast_i ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? period_q : cnt_q - 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == '0);

  a_r5_period_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !start_i |=> $stable(period_q));
endmodule

// File: rtl/ack_link_shifter.sv
module ack_link_shifter
  import ack_link_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  pkt_kind_e kind_i,
  input  logic [7:0] data_i,
  input  logic      tick_i,
  output logic      busy_o,
  output logic      done_o,
  output pkt_kind_e done_kind_o,
  output logic      line_o
);
  logic [FRAME_W-1:0] shreg_q;
  logic [LEFT_W-1:0]  left_q;
  pkt_kind_e          kind_q;
  logic               busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      left_q  <= '0;
      kind_q  <= PKT_ACK;
      busy_q  <= 1'b0;
    end else if (start_i && !busy_q) begin
      shreg_q <= frame_bits(kind_i, data_i);
      left_q  <= frame_last(kind_i);
      kind_q  <= kind_i;
      busy_q  <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (left_q == '0) begin
        busy_q  <= 1'b0;
        shreg_q <= '0;
      end else begin
        shreg_q <= shreg_q >> 1;
        left_q  <= left_q - 1'b1;
      end
    end
  end

  assign line_o      = shreg_q[0];
  assign busy_o      = busy_q;
  assign done_o      = busy_q && tick_i && (left_q == '0);
  assign done_kind_o = kind_q;

  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !line_o);
  a_r5_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i |=> $stable(line_o));
  a_r2_gap_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
endmodule

// File: rtl/ack_link_sched.sv
module ack_link_sched
  import ack_link_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  input  logic       ack_req_i,
  input  logic       ack_rcvd_i,
  input  logic       busy_i,
  input  logic       done_i,
  input  pkt_kind_e  done_kind_i,
  output logic       start_o,
  output pkt_kind_e  kind_o,
  output logic [7:0] data_o,
  output logic       ready_o
);
  logic       ack_pend_q, data_pend_q, outst_q, sent_q;
  logic [7:0] buf_q;
  logic       load_acc, start_ack, start_data;

  assign load_acc   = load_i && !outst_q;
  assign start_o    = !busy_i && (ack_pend_q || data_pend_q);
  assign kind_o     = ack_pend_q ? PKT_ACK : PKT_DATA;
  assign start_ack  = start_o && ack_pend_q;
  assign start_data = start_o && !ack_pend_q;
  assign data_o     = buf_q;
  assign ready_o    = !outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_pend_q  <= 1'b0;
      data_pend_q <= 1'b0;
      outst_q     <= 1'b0;
      sent_q      <= 1'b0;
      buf_q       <= '0;
    end else begin
      ack_pend_q  <= (ack_pend_q && !start_ack) || ack_req_i;
      data_pend_q <= (data_pend_q && !start_data) || load_acc;
      if (load_acc) begin
        buf_q   <= load_data_i;
        outst_q <= 1'b1;
        sent_q  <= 1'b0;
      end else if (ack_rcvd_i && sent_q) begin
        outst_q <= 1'b0;
        sent_q  <= 1'b0;
      end else if (done_i && done_kind_i == PKT_DATA) begin
        sent_q <= 1'b1;
      end
    end
  end

  a_r8_buf_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !ready_o |=> $stable(buf_q));
  a_r9_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_pend_q && !start_o |=> ack_pend_q);
  a_r10_ack_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && ack_pend_q |-> kind_o == PKT_ACK);
  a_r7_ready_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(ack_rcvd_i));
  a_r6_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ready_o |=> !ready_o);
endmodule

// File: rtl/ack_link_tx.sv
module ack_link_tx
  import ack_link_pkg::*;
#(
  parameter int DIV_SLOW = 8,
  parameter int DIV_FAST = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fast_i,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  input  logic       ack_req_i,
  input  logic       ack_rcvd_i,
  output logic       line_o,
  output logic       ready_o
);
  logic       start, busy, done, tick;
  pkt_kind_e  kind, done_kind;
  logic [7:0] data;

  ack_link_sched u_sched (
    .clk_i, .rst_ni, .load_i, .load_data_i, .ack_req_i, .ack_rcvd_i,
    .busy_i(busy), .done_i(done), .done_kind_i(done_kind),
    .start_o(start), .kind_o(kind), .data_o(data), .ready_o
  );

  ack_link_bit_timer #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .fast_i, .run_i(busy), .tick_o(tick)
  );

  ack_link_shifter u_shift (
    .clk_i, .rst_ni, .start_i(start), .kind_i(kind), .data_i(data),
    .tick_i(tick), .busy_o(busy), .done_o(done), .done_kind_o(done_kind),
    .line_o
  );

  a_r1_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> !line_o && ready_o);
endmodule

// File: tb/tb_ack_link_tx.sv
module tb_ack_link_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DSLOW = 8;
  localparam int DFAST = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fast = 1'b0, load = 1'b0, ack_req = 1'b0, ack_rcvd = 1'b0;
  logic [7:0] ldata = '0;
  logic line, ready;

  int total = 0, fails = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ack_link_tx #(.DIV_SLOW(DSLOW), .DIV_FAST(DFAST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fast_i(fast), .load_i(load),
    .load_data_i(ldata), .ack_req_i(ack_req), .ack_rcvd_i(ack_rcvd),
    .line_o(line), .ready_o(ready)
  );

  // reference model: queue of upcoming line values; 2 marks end of data packet, 3 end of ack
  int   q[$];
  bit   m_line = 0, m_apend = 0, m_dpend = 0, m_out = 0, m_sent = 0;
  byte  m_buf;

  task automatic push_bit(bit b, int div);
    for (int k = 0; k < div; k++) q.push_back(int'(b));
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_line = 0; m_apend = 0; m_dpend = 0; m_out = 0; m_sent = 0;
    end else begin
      bit old_ready;
      int div;
      old_ready = !m_out;
      if (q.size() == 0 && (m_apend || m_dpend)) begin
        div = fast ? DFAST : DSLOW;
        if (m_apend) begin
          push_bit(1, div); push_bit(0, div); q.push_back(3); m_apend = 0;
        end else begin
          push_bit(1, div); push_bit(1, div);
          for (int i = 0; i < 8; i++) push_bit(m_buf[i], div);
          push_bit(0, div); q.push_back(2); m_dpend = 0;
        end
      end
      if (ack_req) m_apend = 1;
      if (load && old_ready) begin
        m_dpend = 1; m_buf = ldata; m_out = 1; m_sent = 0;
      end else if (ack_rcvd && m_sent) begin
        m_out = 0; m_sent = 0;
      end else if (q.size() != 0 && q[0] == 2) begin
        m_sent = 1;
      end
      if (q.size() != 0) begin
        int v;
        v = q.pop_front();
        m_line = (v == 1);
      end else m_line = 0;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cur_req, "line_o", line, m_line);
    check(cur_req, "ready_o", ready, !m_out);
  end

  task automatic cyc(bit l, byte d, bit a, bit r);
    @(negedge clk);
    load = l; ldata = d; ack_req = a; ack_rcvd = r;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1", "reset line_o", line, 1'b0);
        check("R1", "reset ready_o", ready, 1'b1);
        rst_n = 1'b1;
        cur_req = "R2"; idle(6);
        // R3 / R6: slow data packet
        cur_req = "R3"; cyc(1, 8'hA5, 0, 0); idle(2);
        check("R6", "ready low after load", ready, 1'b0);
        idle(40);
        cur_req = "R7"; cyc(0, 0, 0, 1);   // early ack_rcvd, ignored
        idle(60);
        check("R7", "ready after early ack", ready, 1'b0);
        cyc(0, 0, 0, 1); idle(2);
        check("R7", "ready after real ack", ready, 1'b1);
        // R8 load while busy, R9 ack request during data
        cur_req = "R8"; cyc(1, 8'h5A, 0, 0); cyc(1, 8'hFF, 0, 0); idle(18);
        cur_req = "R9"; cyc(0, 0, 1, 0); idle(110);
        cyc(0, 0, 0, 1); idle(3);
        // R5: fast packet with fast_i changed mid-packet
        cur_req = "R5"; fast = 1'b1; cyc(1, 8'h3C, 0, 0); idle(6);
        fast = 1'b0; idle(60);
        cyc(0, 0, 0, 1); idle(3);
        // R10 / R4: simultaneous requests
        cur_req = "R10"; cyc(1, 8'h81, 1, 0); idle(120);
        cyc(0, 0, 0, 1); idle(3);
        cur_req = "R4"; fast = 1'b1; cyc(0, 0, 1, 0); idle(20);
        cur_req = "R2"; idle(5);
      end
      begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule